// File: doc/BRIEF.md
# Bank-Concatenating Reconfigurable Cache Controller

This block is a write-back cache built from four identical storage banks. A small set of configuration inputs sets how the banks are used: as four ways, as two pairs that each hold two ways, or as four direct-mapped slices that together form one large set array. Any bank can also be switched off. In that case it is never looked up and never filled. A separate setting fixes how many words are fetched on a miss: 4, 8 or 16. The storage unit is always a 4-word basic line, and longer fetches fill a run of neighbouring basic lines into the same bank.

The processor side uses a single request port. A request is held until `cpu_ready` rises, and a hit completes in the same cycle it is presented. The memory side moves one word per beat, and a beat completes when `mem_valid` and `mem_ready` are both high. When any configuration input changes, the controller first writes every dirty line back to memory and clears the whole cache. Only then does it apply the new setting and accept requests again. Two counters record how many requests hit and how many went to memory.

Top module: `bankcat_cache`

## Requirements
- R1: A request whose word is resident completes in the cycle it is presented with `cpu_ready` high. A read returns the value most recently written to that word address.
- R2: Word address bits [1:0] select the word and bits [IB+1:2] select the set, where IB = log2(SETS). The tag is every bit above that in all modes. `cfg_assoc`=0 (direct-mapped) uses bits [IB+3:IB+2] as the bank number. `cfg_assoc`=1 uses bit IB+2 to pick bank pair {0,1} (bit clear) or {2,3} (bit set). Values 2 and 3 make all four banks ways of one set.
- R3: In four-way mode, four lines with the same set index stay resident together. A fifth line replaces the enabled way that a per-set round-robin pointer selects, starting with bank 0 after reset.
- R4: A bank whose `cfg_way_en` bit is 0 is neither looked up nor filled.
- R5: A miss fetches an aligned block of 4, 8 or 16 words for `cfg_fill` = 0, 1 or 2/3 respectively. Basic lines of the block that are already resident are skipped.
- R6: Writes are write-back and write-allocate. A write miss fills the line and then writes into it without writing memory. A dirty victim's four words go to memory before any fill beat of its replacement.
- R7: A change on any configuration input writes back all dirty lines, invalidates all lines and then applies the new setting. `cpu_ready` stays low for the whole flush.
- R8: If no enabled bank can hold an address, the request becomes a single uncached memory beat, a read or a write, and counts as a miss.
- R9: `hit_count` rises by one for each request served without memory traffic. `miss_count` rises by one for each request that needed memory. Both are zero after reset.
- R10: Once `mem_valid` is raised, it stays high with the same address and direction until `mem_ready` is seen.
- R11: No line is ever resident in two banks at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_assoc | input | 2 | Bank arrangement: 0 direct, 1 two-way, 2/3 four-way |
| cfg_way_en | input | 4 | Per-bank enable |
| cfg_fill | input | 2 | Words fetched per miss: 0→4, 1→8, 2/3→16 |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DW | Read data, valid with `cpu_ready` |
| mem_valid | output | 1 | Memory beat requested |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW | Word address of the beat |
| mem_wdata | output | DW | Write data of the beat |
| mem_ready | input | 1 | Memory accepts or returns the beat |
| mem_rdata | input | DW | Read data, valid with `mem_ready` |
| hit_count | output | CNTW | Requests served from the cache |
| miss_count | output | CNTW | Requests that needed memory |

## Verification
The assertions assume that the processor keeps `cpu_valid`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady until `cpu_ready`. They also assume that memory returns read data in the same cycle as `mem_ready`. Without these conditions the memory-hold property could not be stated for uncached beats. The stimulus drives each request once at a falling edge and holds it until completion. It changes the configuration only between requests. On some runs it toggles `mem_ready` every cycle to exercise stalled beats.

// File: rtl/bankcat_pkg.sv
package bankcat_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_WB,
      ST_FILL,
      ST_UNC,
      ST_FLUSH
   } bc_state_t;
endpackage

// File: rtl/bankcat_map.sv
module bankcat_map #(
   parameter int AW = 12,
   parameter int IB = 4,
   localparam int TW = AW - 2 - IB
) (
   input  logic [AW-1:0] addr,
   input  logic [1:0]    assoc,
   input  logic [3:0]    en,
   output logic [IB-1:0] idx,
   output logic [TW-1:0] tag,
   output logic [3:0]    cand
);
   logic [1:0] bsel;
   logic [3:0] raw;

   assign idx  = addr[IB+1:2];
   assign tag  = addr[AW-1:IB+2];
   assign bsel = addr[IB+3:IB+2];

   always_comb begin
      case (assoc)
         2'd0:    raw = 4'b0001 << bsel;
         2'd1:    raw = bsel[0] ? 4'b1100 : 4'b0011;
         default: raw = 4'b1111;
      endcase
   end

   assign cand = raw & en;
endmodule

// File: rtl/bankcat_victim.sv
module bankcat_victim (
   input  logic [3:0] cand,
   input  logic [1:0] ptr,
   output logic [1:0] way
);
   always_comb begin
      logic found;
      found = 1'b0;
      way   = ptr;
      for (int i = 0; i < 4; i++) begin
         if (!found && cand[ptr + 2'(i)]) begin
            way   = ptr + 2'(i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/bankcat_cache.sv
module bankcat_cache
   import bankcat_pkg::*;
#(
   parameter int AW   = 12,
   parameter int DW   = 32,
   parameter int SETS = 16,
   parameter int CNTW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      cfg_assoc,
   input  logic [3:0]      cfg_way_en,
   input  logic [1:0]      cfg_fill,
   input  logic            cpu_valid,
   input  logic            cpu_we,
   input  logic [AW-1:0]   cpu_addr,
   input  logic [DW-1:0]   cpu_wdata,
   output logic            cpu_ready,
   output logic [DW-1:0]   cpu_rdata,
   output logic            mem_valid,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   input  logic            mem_ready,
   input  logic [DW-1:0]   mem_rdata,
   output logic [CNTW-1:0] hit_count,
   output logic [CNTW-1:0] miss_count
);
   localparam int IB = $clog2(SETS);
   localparam int TW = AW - 2 - IB;
   localparam int LW = AW - 2;
   localparam int FW = IB + 2;

   generate
      if (SETS != (1 << IB) || IB < 2) begin : g_bad_sets
         $error("SETS must be a power of two of at least 4");
      end
      if (TW < 2) begin : g_bad_aw
         $error("AW too small for bank-select bits in the tag");
      end
   endgenerate

   bc_state_t     state_q;
   logic [1:0]    assoc_q, fill_q, vict_q, k_q, beat_q;
   logic [3:0]    en_q;
   logic [LW-1:0] base_q;
   logic [FW-1:0] fl_q;
   logic          was_miss_q;
   logic [CNTW-1:0] hit_q, miss_q;

   logic [DW-1:0] data_q [4][SETS][4];
   logic [TW-1:0] tag_q  [4][SETS];
   logic          val_q  [4][SETS];
   logic          dty_q  [4][SETS];
   logic [1:0]    rr_q   [SETS];

   logic [LW-1:0] cur_line, grp_mask;
   logic [AW-1:0] look_addr;
   logic [IB-1:0] idx, ai;
   logic [TW-1:0] tag;
   logic [3:0]    cand, hitv;
   logic [1:0]    hw, vpick, aw, klast;
   logic          any_hit, cfg_diff, dirty_line, fl_last;

   assign klast    = (fill_q == 2'd0) ? 2'd0 : (fill_q == 2'd1) ? 2'd1 : 2'd3;
   assign grp_mask = ~LW'(klast);
   assign cur_line = base_q | LW'(k_q);
   assign look_addr = (state_q == ST_IDLE || state_q == ST_UNC) ? cpu_addr : {cur_line, 2'b00};
   assign cfg_diff = (cfg_assoc != assoc_q) || (cfg_way_en != en_q) || (cfg_fill != fill_q);

   bankcat_map #(.AW(AW), .IB(IB)) u_map (
      .addr(look_addr), .assoc(assoc_q), .en(en_q), .idx(idx), .tag(tag), .cand(cand)
   );

   bankcat_victim u_vict (.cand(cand), .ptr(rr_q[idx]), .way(vpick));

   genvar gw;
   generate
      for (gw = 0; gw < 4; gw++) begin : g_cmp
         assign hitv[gw] = cand[gw] && val_q[gw][idx] && (tag_q[gw][idx] == tag);
      end
   endgenerate

   always_comb begin
      hw = 2'd0;
      for (int i = 0; i < 4; i++) if (hitv[i]) hw = 2'(i);
   end
   assign any_hit = |hitv;

   assign aw         = (state_q == ST_FLUSH) ? fl_q[IB+1:IB] : vict_q;
   assign ai         = (state_q == ST_FLUSH) ? fl_q[IB-1:0] : idx;
   assign dirty_line = val_q[aw][ai] && dty_q[aw][ai];
   assign fl_last    = (fl_q == '1);

   assign cpu_ready = (state_q == ST_IDLE && cpu_valid && !cfg_diff && any_hit) ||
                      (state_q == ST_UNC && mem_ready);
   assign cpu_rdata = (state_q == ST_UNC) ? mem_rdata : data_q[hw][idx][cpu_addr[1:0]];
   assign mem_valid = (state_q == ST_WB) || (state_q == ST_FILL) || (state_q == ST_UNC) ||
                      (state_q == ST_FLUSH && dirty_line);
   assign mem_we    = (state_q == ST_WB) || (state_q == ST_FLUSH) || (state_q == ST_UNC && cpu_we);
   assign mem_addr  = (state_q == ST_FILL) ? {cur_line, beat_q} :
                      (state_q == ST_UNC)  ? cpu_addr : {tag_q[aw][ai], ai, beat_q};
   assign mem_wdata = (state_q == ST_UNC) ? cpu_wdata : data_q[aw][ai][beat_q];
   assign hit_count  = hit_q;
   assign miss_count = miss_q;

   // data store write port: processor write hit or fill beat
   logic          dw_en;
   logic [1:0]    dw_way, dw_word;
   logic [DW-1:0] dw_val;
   always_comb begin
      dw_en = 1'b0; dw_way = hw; dw_word = cpu_addr[1:0]; dw_val = cpu_wdata;
      if (state_q == ST_IDLE && cpu_ready && cpu_we) dw_en = 1'b1;
      if (state_q == ST_FILL && mem_ready) begin
         dw_en = 1'b1; dw_way = vict_q; dw_word = beat_q; dw_val = mem_rdata;
      end
   end

   always_ff @(posedge clk) begin
      if (dw_en) data_q[dw_way][idx][dw_word] <= dw_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE; assoc_q <= 2'd2; en_q <= 4'hF; fill_q <= 2'd0;
         vict_q <= '0; k_q <= '0; beat_q <= '0; base_q <= '0; fl_q <= '0;
         was_miss_q <= 1'b0; hit_q <= '0; miss_q <= '0;
         for (int w = 0; w < 4; w++)
            for (int s = 0; s < SETS; s++) begin
               val_q[w][s] <= 1'b0; dty_q[w][s] <= 1'b0; tag_q[w][s] <= '0;
            end
         for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (cfg_diff) begin
                  state_q <= ST_FLUSH; fl_q <= '0; beat_q <= '0;
               end else if (cpu_valid) begin
                  if (any_hit) begin
                     if (cpu_we) dty_q[hw][idx] <= 1'b1;
                     if (!was_miss_q) hit_q <= hit_q + 1'b1;
                     was_miss_q <= 1'b0;
                  end else if (cand == 4'd0) begin
                     miss_q <= miss_q + 1'b1; state_q <= ST_UNC;
                  end else begin
                     miss_q <= miss_q + 1'b1; was_miss_q <= 1'b1;
                     vict_q <= vpick; rr_q[idx] <= vpick + 2'd1;
                     base_q <= cpu_addr[AW-1:2] & grp_mask; k_q <= '0;
                     state_q <= ST_LOOK;
                  end
               end
            end
            ST_LOOK: begin
               if (any_hit) begin
                  if (k_q == klast) state_q <= ST_IDLE;
                  else k_q <= k_q + 2'd1;
               end else begin
                  beat_q <= '0;
                  state_q <= dirty_line ? ST_WB : ST_FILL;
               end
            end
            ST_WB: if (mem_ready) begin
               beat_q <= beat_q + 2'd1;
               if (beat_q == 2'd3) state_q <= ST_FILL;
            end
            ST_FILL: if (mem_ready) begin
               beat_q <= beat_q + 2'd1;
               if (beat_q == 2'd3) begin
                  tag_q[vict_q][idx] <= tag; val_q[vict_q][idx] <= 1'b1;
                  dty_q[vict_q][idx] <= 1'b0;
                  if (k_q == klast) state_q <= ST_IDLE;
                  else begin k_q <= k_q + 2'd1; state_q <= ST_LOOK; end
               end
            end
            ST_UNC: if (mem_ready) state_q <= ST_IDLE;
            ST_FLUSH: begin
               if (!dirty_line || (mem_ready && beat_q == 2'd3)) begin
                  val_q[aw][ai] <= 1'b0; dty_q[aw][ai] <= 1'b0; beat_q <= '0;
                  if (fl_last) begin
                     assoc_q <= cfg_assoc; en_q <= cfg_way_en; fill_q <= cfg_fill;
                     state_q <= ST_IDLE;
                  end else fl_q <= fl_q + 1'b1;
               end else if (mem_ready) beat_q <= beat_q + 2'd1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_ONE_BANK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hitv)); // R11
   AST_FLUSH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FLUSH) |-> !cpu_ready); // R7
   AST_FILL_ENABLED_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FILL) |-> en_q[vict_q]); // R4
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we))); // R10
   AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (miss_q == $past(miss_q) || miss_q == $past(miss_q) + 1'b1)); // R9
endmodule

// File: tb/bankcat_cache_test.sv
module bankcat_cache_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [1:0]  cfg_assoc = 2'd2, cfg_fill = 2'd0;
   logic [3:0]  cfg_way_en = 4'hF;
   logic        cpu_valid = 1'b0, cpu_we = 1'b0, cpu_ready;
   logic [11:0] cpu_addr = '0, mem_addr;
   logic [31:0] cpu_wdata = '0, cpu_rdata, mem_wdata, mem_rdata;
   logic        mem_valid, mem_we, mem_ready = 1'b1, stall = 1'b0;
   logic [31:0] hit_count, miss_count;

   logic [31:0] mem  [4096];
   logic [31:0] gold [4096];
   int nchk = 0, nfail = 0, rd_beats = 0, wr_beats = 0, cycles = 0;
   bit rd_seen, order_bad;
   int l_cyc, l_rb, l_wb, l_hd, l_md;

   always #(CLK_P/2) clk = ~clk;
   assign mem_rdata = mem[mem_addr];
   always @(negedge clk) mem_ready <= stall ? ~mem_ready : 1'b1;

   bankcat_cache uut (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   // compare against the behavioural model just before every rising edge
   always @(negedge clk) begin
      #(CLK_P/2 - 1);
      if (rst_n) begin
         if (cpu_valid && cpu_ready) begin
            if (cpu_we) gold[cpu_addr] = cpu_wdata;
            else chk(cpu_rdata == gold[cpu_addr], "R1 read data", cpu_rdata, gold[cpu_addr]);
         end
         if (mem_valid && mem_ready) begin
            if (mem_we) begin
               mem[mem_addr] = mem_wdata; wr_beats++;
               if (rd_seen) order_bad = 1'b1;
            end else begin
               rd_beats++; rd_seen = 1'b1;
            end
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         nfail++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   task automatic acc(input logic we, input logic [11:0] a, input logic [31:0] d);
      int h0, m0, r0, w0;
      h0 = hit_count; m0 = miss_count; r0 = rd_beats; w0 = wr_beats;
      rd_seen = 1'b0; order_bad = 1'b0;
      cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_valid = 1'b1; l_cyc = 0;
      forever begin
         #1;
         if (cpu_ready) break;
         @(negedge clk); l_cyc++;
      end
      @(negedge clk);
      cpu_valid = 1'b0;
      l_rb = rd_beats - r0; l_wb = wr_beats - w0;
      l_hd = hit_count - h0; l_md = miss_count - m0;
   endtask

   task automatic exp_hit(input string req);
      chk(l_cyc == 0, {req, " hit latency"}, l_cyc, 0);
      chk(l_hd == 1 && l_md == 0 && l_rb == 0, {req, " hit counted"}, l_hd, 1);
   endtask

   task automatic exp_miss(input string req, input int rb, input int wb);
      chk(l_md == 1 && l_hd == 0, {req, " miss counted"}, l_md, 1);
      chk(l_rb == rb, {req, " fill beats"}, l_rb, rb);
      chk(l_wb == wb, {req, " write-back beats"}, l_wb, wb);
   endtask

   task automatic setcfg(input logic [1:0] as, input logic [3:0] en, input logic [1:0] fl);
      cfg_assoc = as; cfg_way_en = en; cfg_fill = fl;
   endtask

   initial begin
      int pair_rb;
      for (int i = 0; i < 4096; i++) begin
         mem[i] = 32'(i) * 32'h9E37 + 32'h55;
         gold[i] = mem[i];
      end
      repeat (4) @(negedge clk);
      chk(hit_count == 0 && miss_count == 0, "R9 reset counters", hit_count + miss_count, 0);
      chk(!cpu_ready && !mem_valid, "R10 reset idle outputs", mem_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // basic miss then hit, 4-word fill
      acc(0, 12'h040, 0); exp_miss("R5 first miss", 4, 0);
      acc(0, 12'h040, 0); exp_hit("R1 reread");
      acc(1, 12'h041, 32'hCAFE0001); exp_hit("R1 write hit");
      acc(0, 12'h041, 0); exp_hit("R1 read after write");

      // four-way residency and round-robin replacement in set 0
      acc(0, 12'h080, 0); exp_miss("R3 fill way1", 4, 0);
      acc(0, 12'h0C0, 0); exp_miss("R3 fill way2", 4, 0);
      acc(0, 12'h100, 0); exp_miss("R3 fill way3", 4, 0);
      acc(0, 12'h040, 0); exp_hit("R3 resident a");
      acc(0, 12'h080, 0); exp_hit("R3 resident b");
      acc(0, 12'h0C0, 0); exp_hit("R3 resident c");
      acc(0, 12'h100, 0); exp_hit("R3 resident d");
      acc(0, 12'h140, 0); exp_miss("R6 dirty victim", 4, 4);
      chk(!order_bad, "R6 write-back before fill", order_bad, 0);
      acc(0, 12'h080, 0); exp_hit("R3 survivor");
      acc(0, 12'h040, 0); exp_miss("R3 evicted oldest", 4, 0);
      acc(0, 12'h0C0, 0); exp_hit("R3 second survivor");

      // write-allocate, no write-through
      acc(1, 12'h145, 32'h0BADF00D); exp_miss("R6 write miss", 4, 0);
      chk(mem[12'h145] != 32'h0BADF00D, "R6 no write-through", mem[12'h145], 0);

      // reconfigure: flush, then 16-word fills
      setcfg(2'd2, 4'hF, 2'd2);
      acc(0, 12'h200, 0);
      chk(l_cyc >= 64, "R7 ready held low during flush", l_cyc, 64);
      chk(mem[12'h145] == 32'h0BADF00D, "R7 dirty data flushed", mem[12'h145], 32'h0BADF00D);
      exp_miss("R5 sixteen-word fill", 16, 4);
      acc(0, 12'h20C, 0); exp_hit("R5 neighbour in block");
      acc(0, 12'h23F, 0); exp_miss("R5 next block", 16, 0);
      acc(0, 12'h230, 0); exp_hit("R5 within upper block");

      // direct-mapped: bank chosen by bits [7:6]
      setcfg(2'd0, 4'hF, 2'd0);
      acc(0, 12'h400, 0); exp_miss("R2 direct bank0", 4, 0);
      acc(0, 12'h440, 0); exp_miss("R2 direct bank1", 4, 0);
      acc(0, 12'h400, 0); exp_hit("R2 direct keep bank0");
      acc(0, 12'h440, 0); exp_hit("R2 direct keep bank1");
      acc(0, 12'h500, 0); exp_miss("R2 direct conflict", 4, 0);
      acc(0, 12'h400, 0); exp_miss("R2 direct displaced", 4, 0);
      acc(0, 12'h440, 0); exp_hit("R2 direct other bank intact");

      // two-way: bit 6 picks the bank pair
      setcfg(2'd1, 4'hF, 2'd0);
      acc(0, 12'h400, 0); exp_miss("R2 pair0 a", 4, 0);
      acc(0, 12'h480, 0); exp_miss("R2 pair0 b", 4, 0);
      acc(0, 12'h400, 0); exp_hit("R2 pair0 a kept");
      acc(0, 12'h480, 0); exp_hit("R2 pair0 b kept");
      acc(0, 12'h500, 0); exp_miss("R2 pair0 third", 4, 0);
      acc(0, 12'h440, 0); exp_miss("R2 pair1", 4, 0);
      acc(0, 12'h500, 0); exp_hit("R2 pair0 third kept");
      acc(0, 12'h440, 0); exp_hit("R2 pair1 kept");
      pair_rb = 0;
      acc(0, 12'h400, 0); pair_rb += l_rb;
      acc(0, 12'h480, 0); pair_rb += l_rb;
      chk(pair_rb >= 4, "R2 pair holds only two", pair_rb, 4);

      // single enabled bank, with stalled memory beats
      stall = 1'b1;
      setcfg(2'd2, 4'b0001, 2'd0);
      acc(0, 12'h040, 0); exp_miss("R4 one bank a", 4, 0);
      acc(0, 12'h080, 0); exp_miss("R4 one bank b", 4, 0);
      acc(0, 12'h040, 0); exp_miss("R4 disabled banks unused", 4, 0);
      stall = 1'b0;

      // uncached path when the only candidate bank is off
      setcfg(2'd0, 4'b1110, 2'd0);
      acc(0, 12'h640, 0); exp_miss("R8 enabled bank caches", 4, 0);
      acc(0, 12'h600, 0); exp_miss("R8 uncached read", 1, 0);
      chk(l_cyc == 1, "R8 uncached latency", l_cyc, 1);
      acc(1, 12'h601, 32'h600D600D); exp_miss("R8 uncached write", 0, 1);
      chk(mem[12'h601] == 32'h600D600D, "R8 write reached memory", mem[12'h601], 32'h600D600D);
      acc(0, 12'h601, 0); exp_miss("R8 uncached reread", 1, 0);
      acc(0, 12'h640, 0); exp_hit("R8 cached line kept");

      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule